// File: doc/BRIEF.md
# Short I/O Register Window Decoder with Location Monitor

This block watches accesses in the supervisor short I/O address space and does two jobs. First, it decides whether an access falls inside a small window of eight control and status registers, and which of the eight it addresses. A 4-bit base value, held in a local register, places the window. The window answers only when the upper address byte is zero and the base value is not all ones. Reset loads all ones, so the window stays silent until local software moves it.

Second, a location monitor watches two fixed addresses. A two-byte access at the even address or a low-byte-only access at the odd address trips an active-low flag. While the flag is low and the interrupt is enabled, a utility interrupt request at level 2 is raised. An interrupt acknowledge re-arms the flag, and so does a local write of 1. Like the window, the monitor is inert while the base value is all ones. A second local register holds the flag and the interrupt enable. A read-only identification nibble shares a local register with the base value.

Top module: `sio_window_top`

## Requirements
- R1: After reset the base value is 0xF, the monitor flag is 1 and the interrupt enable is 0. Local register 0 reads 0x1F and local register 1 reads 0x01.
- R2: `win_hit` is high in the same cycle as an access if and only if all of these hold: `acc_valid` is high, `acc_sup_sio` is high, at least one byte strobe is set, address bits 15:8 are zero, address bits 7:4 equal the base value, and the base value is not 0xF.
- R3: While `win_hit` is high, `win_sel` equals address bits 3:1; otherwise it is 0. `win_wr_hit` equals `win_hit` AND `acc_wr`.
- R4: While the base value is 0xF, no access raises `win_hit` and no access trips the monitor.
- R5: Local register 0 reads as {ID nibble, base value}, and the ID nibble is always 4'b0001.
- R6: The monitor flag goes to 0 at the next clock edge after a qualified access. A qualified access has `acc_valid` and `acc_sup_sio` high and the window enabled, and is either of these: address 0x00F0 with both strobes set, or address 0x00F1 with only `acc_ds_lo` set. No other access trips the flag.
- R7: `uirq2` is high exactly when the monitor flag is 0 and the interrupt enable is 1.
- R8: The monitor flag returns to 1 at the next edge after `irq_ack`, or after a local write to register 1 with data bit 0 set. A write with data bit 0 clear leaves the flag unchanged.
- R9: If a qualified access and a re-arm arrive in the same cycle, the flag ends at 0.
- R10: A local write (`loc_we` high) takes effect at the next edge. With `loc_addr` = 0, data bits 3:0 become the base value. With `loc_addr` = 1, data bit 1 becomes the interrupt enable and data bit 0 acts as described in R8. Register 1 reads {zeros, enable, flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 16 | Short I/O address |
| acc_sup_sio | input | 1 | Address modifier is supervisor short I/O |
| acc_ds_hi | input | 1 | Even (high) byte strobe |
| acc_ds_lo | input | 1 | Odd (low) byte strobe |
| acc_wr | input | 1 | Access is a write |
| irq_ack | input | 1 | Utility interrupt acknowledge |
| loc_we | input | 1 | Local register write strobe |
| loc_addr | input | 1 | Local register index (0 base/ID, 1 monitor) |
| loc_wdata | input | 4 | Local write data |
| loc_rdata | output | 8 | Local read data for `loc_addr` |
| win_hit | output | 1 | Access falls in the register window |
| win_wr_hit | output | 1 | Window hit by a write |
| win_sel | output | 3 | Register index inside the window |
| mon_n | output | 1 | Location monitor flag, active low |
| uirq2 | output | 1 | Utility interrupt request, level 2 |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 4-bit base and unregistered window outputs. At that size the whole low address byte, all four strobe pairs and three qualification cases can be swept for each of the sixteen base values, including the disabled value 0xF. The monitor's two trigger addresses are therefore reached under every strobe pattern, with the enable both on and off. Probes with the upper address byte nonzero, and directed sequences for same-cycle trip and re-arm, write-0, and acknowledge while idle, cover the rest.

// File: rtl/sio_win_pkg.sv
package sio_win_pkg;

   // Local register indices
   typedef enum logic {
      LREG_BASE = 1'b0,
      LREG_MON  = 1'b1
   } lreg_e;

   // Byte-lane width of an access
   typedef enum logic [1:0] {
      XFER_NONE = 2'd0,
      XFER_HI   = 2'd1,
      XFER_LO   = 2'd2,
      XFER_DBL  = 2'd3
   } xfer_e;

   function automatic xfer_e xfer_kind(input logic ds_hi, input logic ds_lo);
      xfer_e k;
      case ({ds_hi, ds_lo})
         2'b11:   k = XFER_DBL;
         2'b10:   k = XFER_HI;
         2'b01:   k = XFER_LO;
         default: k = XFER_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/sio_lreg.sv
module sio_lreg
   import sio_win_pkg::*;
#(
   parameter int BASE_W = 4,
   parameter int ID_W   = 4,
   parameter logic [ID_W-1:0] ID_VALUE = 4'b0001,
   localparam int LDW = ID_W + BASE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              addr,
   input  logic [BASE_W-1:0] wdata,
   input  logic              mon_n,
   output logic [BASE_W-1:0] base_q,
   output logic              irq_en_q,
   output logic              rearm_wr,
   output logic [LDW-1:0]    rdata
);

   lreg_e idx;
   assign idx = lreg_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '1;
         irq_en_q <= 1'b0;
      end else if (we) begin
         if (idx == LREG_BASE) base_q   <= wdata;
         else                  irq_en_q <= wdata[1];
      end
   end

   assign rearm_wr = we && (idx == LREG_MON) && wdata[0];

   always_comb begin
      rdata = '0;
      if (idx == LREG_BASE) rdata = {ID_VALUE, base_q};
      else                  rdata[1:0] = {irq_en_q, mon_n};
   end

endmodule

// File: rtl/sio_win_dec.sv
module sio_win_dec
   import sio_win_pkg::*;
#(
   parameter int AW     = 16,
   parameter int BASE_W = 4,
   parameter int SEL_W  = 3,
   localparam int BASE_LSB = SEL_W + 1,
   localparam int HI_LSB   = BASE_LSB + BASE_W
) (
   input  logic              valid,
   input  logic              sup,
   input  logic              ds_hi,
   input  logic              ds_lo,
   input  logic              wr,
   input  logic [AW-1:0]     addr,
   input  logic [BASE_W-1:0] base_q,
   output logic              win_en,
   output logic              hit,
   output logic              wr_hit,
   output logic [SEL_W-1:0]  sel
);

   logic hi_zero;
   logic base_match;
   logic lane_ok;

   assign win_en     = ~(&base_q);
   assign hi_zero    = (addr[AW-1:HI_LSB] == '0);
   assign base_match = (addr[HI_LSB-1:BASE_LSB] == base_q);
   assign lane_ok    = (xfer_kind(ds_hi, ds_lo) != XFER_NONE);

   always_comb begin
      hit    = valid && sup && lane_ok && hi_zero && base_match && win_en;
      wr_hit = hit && wr;
      sel    = hit ? addr[BASE_LSB-1:1] : '0;
   end

   // addr[0] is not part of the window decode
   logic unused_lsb;
   assign unused_lsb = addr[0];

endmodule

// File: rtl/sio_loc_mon.sv
module sio_loc_mon
   import sio_win_pkg::*;
#(
   parameter int AW = 16,
   parameter logic [AW-1:0] MON_ADDR = 16'h00F0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  logic          sup,
   input  logic          ds_hi,
   input  logic          ds_lo,
   input  logic [AW-1:0] addr,
   input  logic          win_en,
   input  logic          ack,
   input  logic          rearm_wr,
   input  logic          irq_en,
   output logic          mon_n,
   output logic          uirq
);

   localparam logic [AW-1:0] MON_ODD = MON_ADDR | AW'(1);

   xfer_e kind;
   logic  trip;

   assign kind = xfer_kind(ds_hi, ds_lo);

   always_comb begin
      trip = 1'b0;
      if (valid && sup && win_en) begin
         if (addr == MON_ADDR && kind == XFER_DBL) trip = 1'b1;
         if (addr == MON_ODD  && kind == XFER_LO)  trip = 1'b1;
      end
   end

   // trip has priority over re-arm
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mon_n <= 1'b1;
      else if (trip)             mon_n <= 1'b0;
      else if (ack || rearm_wr)  mon_n <= 1'b1;
   end

   assign uirq = !mon_n && irq_en;

endmodule

// File: rtl/sio_window_top.sv
module sio_window_top #(
   parameter int AW      = 16,
   parameter int BASE_W  = 4,
   parameter int SEL_W   = 3,
   parameter int ID_W    = 4,
   parameter logic [ID_W-1:0] ID_VALUE = 4'b0001,
   parameter logic [AW-1:0]   MON_ADDR = 16'h00F0,
   parameter bit  OUT_REG = 1'b0,
   localparam int LDW    = ID_W + BASE_W,
   localparam int HI_LSB = SEL_W + 1 + BASE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [AW-1:0]     acc_addr,
   input  logic              acc_sup_sio,
   input  logic              acc_ds_hi,
   input  logic              acc_ds_lo,
   input  logic              acc_wr,
   input  logic              irq_ack,
   input  logic              loc_we,
   input  logic              loc_addr,
   input  logic [BASE_W-1:0] loc_wdata,
   output logic [LDW-1:0]    loc_rdata,
   output logic              win_hit,
   output logic              win_wr_hit,
   output logic [SEL_W-1:0]  win_sel,
   output logic              mon_n,
   output logic              uirq2
);

   generate
      if (HI_LSB >= AW) begin : g_bad_aw
         $error("address too narrow for window");
      end
      if (BASE_W < 2) begin : g_bad_base
         $error("base field must be at least 2 bits");
      end
      if (MON_ADDR[0] != 1'b0) begin : g_bad_mon
         $error("monitor address must be even");
      end
   endgenerate

   logic [BASE_W-1:0] base_q;
   logic              irq_en_q;
   logic              rearm_wr;
   logic              win_en;
   logic              d_hit;
   logic              d_wr_hit;
   logic [SEL_W-1:0]  d_sel;

   sio_lreg #(
      .BASE_W(BASE_W), .ID_W(ID_W), .ID_VALUE(ID_VALUE)
   ) u_lreg (
      .clk(clk), .rst_n(rst_n), .we(loc_we), .addr(loc_addr),
      .wdata(loc_wdata), .mon_n(mon_n), .base_q(base_q),
      .irq_en_q(irq_en_q), .rearm_wr(rearm_wr), .rdata(loc_rdata)
   );

   sio_win_dec #(
      .AW(AW), .BASE_W(BASE_W), .SEL_W(SEL_W)
   ) u_dec (
      .valid(acc_valid), .sup(acc_sup_sio), .ds_hi(acc_ds_hi),
      .ds_lo(acc_ds_lo), .wr(acc_wr), .addr(acc_addr), .base_q(base_q),
      .win_en(win_en), .hit(d_hit), .wr_hit(d_wr_hit), .sel(d_sel)
   );

   sio_loc_mon #(
      .AW(AW), .MON_ADDR(MON_ADDR)
   ) u_mon (
      .clk(clk), .rst_n(rst_n), .valid(acc_valid), .sup(acc_sup_sio),
      .ds_hi(acc_ds_hi), .ds_lo(acc_ds_lo), .addr(acc_addr),
      .win_en(win_en), .ack(irq_ack), .rearm_wr(rearm_wr),
      .irq_en(irq_en_q), .mon_n(mon_n), .uirq(uirq2)
   );

   generate
      if (OUT_REG) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_hit    <= 1'b0;
               win_wr_hit <= 1'b0;
               win_sel    <= '0;
            end else begin
               win_hit    <= d_hit;
               win_wr_hit <= d_wr_hit;
               win_sel    <= d_sel;
            end
         end
      end else begin : g_comb_out
         assign win_hit    = d_hit;
         assign win_wr_hit = d_wr_hit;
         assign win_sel    = d_sel;
      end
   endgenerate

endmodule

// File: rtl/sio_window_chk.sv
module sio_window_chk #(
   parameter int  HI_W   = 8,
   parameter int  BASE_W = 4,
   parameter int  SEL_W  = 3,
   parameter bit  OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_sup_sio,
   input logic [HI_W-1:0]   addr_hi,
   input logic              irq_ack,
   input logic              loc_we,
   input logic              loc_addr,
   input logic              loc_wd0,
   input logic [BASE_W-1:0] base_q,
   input logic              win_hit,
   input logic [SEL_W-1:0]  win_sel,
   input logic              mon_n,
   input logic              uirq2
);

   generate
      if (OUT_REG) begin : g_reg
         AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
            win_hit |-> $past(acc_valid && acc_sup_sio && addr_hi == '0)); // R2
         AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(&base_q) |-> !win_hit); // R4
      end else begin : g_comb
         AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
            win_hit |-> (acc_valid && acc_sup_sio && addr_hi == '0)); // R2
         AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (&base_q) |-> !win_hit); // R4
      end
   endgenerate

   AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !win_hit |-> win_sel == '0); // R3

   AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mon_n) |-> $past(acc_valid && acc_sup_sio && !(&base_q))); // R6

   AST_REARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mon_n) |-> $past(irq_ack || (loc_we && loc_addr && loc_wd0))); // R8

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      uirq2 |-> !mon_n); // R7

endmodule

bind sio_window_top sio_window_chk #(
   .HI_W(AW - HI_LSB), .BASE_W(BASE_W), .SEL_W(SEL_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
   .acc_sup_sio(acc_sup_sio), .addr_hi(acc_addr[AW-1:HI_LSB]),
   .irq_ack(irq_ack), .loc_we(loc_we), .loc_addr(loc_addr),
   .loc_wd0(loc_wdata[0]), .base_q(base_q), .win_hit(win_hit),
   .win_sel(win_sel), .mon_n(mon_n), .uirq2(uirq2)
);

// File: tb/tb_sio_window_top.sv
`timescale 1ns/1ps
module tb_sio_window_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [15:0] acc_addr = '0;
   logic        acc_sup_sio = 1'b0;
   logic        acc_ds_hi = 1'b0;
   logic        acc_ds_lo = 1'b0;
   logic        acc_wr = 1'b0;
   logic        irq_ack = 1'b0;
   logic        loc_we = 1'b0;
   logic        loc_addr = 1'b0;
   logic [3:0]  loc_wdata = '0;
   logic [7:0]  loc_rdata;
   logic        win_hit, win_wr_hit, mon_n, uirq2;
   logic [2:0]  win_sel;

   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;
   logic       done = 1'b0;

   // model state
   logic [3:0] m_base = 4'hF;
   logic       m_en   = 1'b0;
   logic       m_flag = 1'b1;
   logic       rearm_sel = 1'b0;

   always #2.5 clk = ~clk;

   sio_window_top dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_sup_sio(acc_sup_sio), .acc_ds_hi(acc_ds_hi), .acc_ds_lo(acc_ds_lo),
      .acc_wr(acc_wr), .irq_ack(irq_ack), .loc_we(loc_we), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .win_hit(win_hit),
      .win_wr_hit(win_wr_hit), .win_sel(win_sel), .mon_n(mon_n), .uirq2(uirq2)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000 && !done) begin
         errors  = errors + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected <190000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors = vectors + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic loc_write(input logic a, input logic [3:0] d);
      @(negedge clk);
      loc_we = 1'b1; loc_addr = a; loc_wdata = d;
      @(posedge clk); #1;
      loc_we = 1'b0;
   endtask

   task automatic chk_mon(input string req);
      chk(req, {31'd0, mon_n}, {31'd0, m_flag});
      chk({req, "_R7"}, {31'd0, uirq2}, {31'd0, !m_flag && m_en});
   endtask

   task automatic rearm();
      if (rearm_sel) begin
         @(negedge clk); irq_ack = 1'b1;
         @(posedge clk); #1; irq_ack = 1'b0;
      end else begin
         loc_write(1'b1, {2'b00, m_en, 1'b1});
      end
      rearm_sel = !rearm_sel;
      m_flag = 1'b1;
      chk_mon("R8_rearm");
   endtask

   // one access; valid/sup/strobes/write given
   task automatic access(input logic [15:0] a, input logic v, input logic s,
                         input logic hi, input logic lo, input logic w);
      logic e_hit, trig;
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_sup_sio = s;
      acc_ds_hi = hi; acc_ds_lo = lo; acc_wr = w;
      #1;
      e_hit = v && s && (hi || lo) && (a[15:8] == 8'h00) &&
              (a[7:4] == m_base) && (m_base != 4'hF);
      chk("R2_R4_hit", {31'd0, win_hit}, {31'd0, e_hit});
      chk("R3_sel", {29'd0, win_sel}, e_hit ? {29'd0, a[3:1]} : 32'd0);
      chk("R3_wr", {31'd0, win_wr_hit}, {31'd0, e_hit && w});
      trig = v && s && (m_base != 4'hF) &&
             ((a == 16'h00F0 && hi && lo) || (a == 16'h00F1 && lo && !hi));
      @(posedge clk); #1;
      acc_valid = 1'b0; acc_ds_hi = 1'b0; acc_ds_lo = 1'b0;
      if (trig) m_flag = 1'b0;
      chk_mon("R6_mon");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state and R5 ID nibble
      loc_addr = 1'b0; #1;
      chk("R1_R5_reg0", {24'd0, loc_rdata}, 32'h1F);
      loc_addr = 1'b1; #1;
      chk("R1_reg1", {24'd0, loc_rdata}, 32'h01);
      chk("R1_mon", {31'd0, mon_n}, 32'd1);
      chk("R1_irq", {31'd0, uirq2}, 32'd0);

      // R4: disabled window ignores the monitor address
      access(16'h00F0, 1, 1, 1, 1, 0);
      access(16'h00F1, 1, 1, 0, 1, 1);

      // main sweep: every base, low byte, strobe pair, qualification case
      for (int b = 0; b < 16; b++) begin
         m_base = b[3:0];
         m_en   = b[0];
         loc_write(1'b0, b[3:0]);                 // R10
         loc_write(1'b1, {2'b00, m_en, 1'b1});
         @(negedge clk); loc_addr = 1'b0; #1;
         chk("R10_R5_reg0", {24'd0, loc_rdata}, {24'd0, 4'h1, b[3:0]});
         loc_addr = 1'b1; #1;
         chk("R10_reg1", {24'd0, loc_rdata}, {30'd0, m_en, m_flag});
         for (int a = 0; a < 256; a++) begin
            for (int ds = 0; ds < 4; ds++) begin
               for (int q = 0; q < 3; q++) begin
                  access({8'h00, a[7:0]}, q != 2, q != 0, ds[1], ds[0], a[0]);
                  if (!m_flag) rearm();
               end
            end
         end
         // upper byte nonzero never hits
         for (int k = 0; k < 8; k++) begin
            access({8'(1 << k), b[3:0], 4'h6}, 1, 1, 1, 1, 1);
            access({8'(1 << k), 8'hF0}, 1, 1, 1, 1, 0);
         end
      end

      // directed corner cases, window at 0xF0 region disabled? use base 0xE
      m_base = 4'hE; m_en = 1'b1;
      loc_write(1'b0, 4'hE);
      loc_write(1'b1, 4'b0010);
      access(16'h00F0, 1, 1, 1, 1, 0);            // trip, R6
      chk("R7_irq_on", {31'd0, uirq2}, 32'd1);
      loc_write(1'b1, 4'b0010);                   // write 0 to flag: no effect R8
      chk_mon("R8_write0");
      rearm();
      @(negedge clk); irq_ack = 1'b1;             // ack while armed: no change R8
      @(posedge clk); #1; irq_ack = 1'b0;
      chk_mon("R8_ack_idle");
      // R9: trip together with ack
      @(negedge clk);
      acc_valid = 1; acc_addr = 16'h00F1; acc_sup_sio = 1;
      acc_ds_hi = 0; acc_ds_lo = 1; irq_ack = 1'b1;
      @(posedge clk); #1;
      acc_valid = 0; acc_ds_lo = 0; irq_ack = 1'b0;
      m_flag = 1'b0;
      chk_mon("R9_trip_vs_ack");
      // R9: trip together with rearm write
      rearm();
      @(negedge clk);
      acc_valid = 1; acc_addr = 16'h00F0; acc_sup_sio = 1;
      acc_ds_hi = 1; acc_ds_lo = 1;
      loc_we = 1; loc_addr = 1; loc_wdata = 4'b0011;
      @(posedge clk); #1;
      acc_valid = 0; acc_ds_hi = 0; acc_ds_lo = 0; loc_we = 0;
      m_flag = 1'b0;
      chk_mon("R9_trip_vs_write");
      // R4: disabling the window with flag low keeps flag, blocks new trips
      loc_write(1'b0, 4'hF); m_base = 4'hF;
      rearm();
      access(16'h00F0, 1, 1, 1, 1, 0);
      chk("R4_still_armed", {31'd0, mon_n}, 32'd1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule